// File: doc/BRIEF.md
# ECC Error Log Register Bank

This block sits beside a memory ECC checker and turns its per-event pulses into state that software can read. Five kinds of event are tracked: a corrected (single-bit) ECC error, an uncorrectable (multi-bit) ECC error, a refresh timeout, a locked access aimed at non-DRAM space, and a thermal sensor event. Each event sets a sticky flag. Software clears a flag by writing one to it.

For the two ECC events, the block also records the failing address, the channel and the syndrome. Address bits 31:7 go into a 32-bit pointer register, so the grain is 128 bytes. The bits above bit 31 go into a small extended register. Details that are already logged are protected. A corrected error never displaces an earlier log. An uncorrectable error displaces a logged corrected error, but never a logged uncorrectable one. This leaves the most severe failure visible to software.

A command register uses the same bit layout as the status flags. Each of its bits lets the matching event raise the system error output. Software reaches all registers through a 32-bit read/write port with byte strobes and byte addresses. Read data is registered.

Top module: `ecc_err_log`

## Requirements
- R1: After a synchronous active-high reset, the status, command, address, extended address and syndrome registers all read zero, and `serr` is low.
- R2: The status word is the low half of offset 0xC8. The events set these bits: corrected ECC error bit 0, uncorrectable ECC error bit 1, refresh timeout bit 8, locked non-DRAM access bit 9, thermal event bit 11. A flag reads one from the cycle after its event pulse. Every other status bit reads zero.
- R3: A write to offset 0xC8 with a byte strobe set clears each status bit whose data bit is one. Status bits whose data bit is zero, or whose byte strobe is clear, keep their value.
- R4: If an event and a write-one-clear reach the same status bit in the same cycle, the bit ends up set.
- R5: Offset 0x58 reads as follows: failing address bits 31:7 in bits 31:7, zero in bits 6:1, and the error channel in bit 0.
- R6: Bit 0 of offset 0x70 holds failing address bit 32, and its other bits read zero. Bits 7:0 of offset 0x5C hold the logged syndrome.
- R7: An uncorrectable error that arrives while only a corrected error is logged replaces the logged address, channel and syndrome.
- R8: A corrected error is not logged while either ECC flag (bit 0 or bit 1) is set. An uncorrectable error is not logged while bit 1 is set. Once both flags are clear, the next ECC error is logged. When both ECC events pulse in the same cycle, the uncorrectable error's details are logged.
- R9: The command register is the high half of offset 0xC8, written through byte strobes 2 and 3. Only positions 0, 1, 8, 9 and 11 (the same as the status bits) hold a value; all other positions read zero.
- R10: `serr` is high for exactly the one cycle after any cycle in which an event pulses and its command bit is set. It stays low for events whose command bit is clear.
- R11: Writes to offsets 0x58, 0x5C and 0x70 have no effect.
- R12: `reg_rdata` changes only on the clock edge that samples `reg_re`, and it holds its value between reads. Unmapped or unaligned offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_ce | input | 1 | Corrected ECC error pulse |
| ev_ue | input | 1 | Uncorrectable ECC error pulse |
| ev_rfto | input | 1 | Refresh timeout pulse |
| ev_lock | input | 1 | Locked access to non-DRAM space pulse |
| ev_therm | input | 1 | Thermal sensor event pulse |
| err_addr | input | PA_W | Failing physical address, valid with ev_ce/ev_ue |
| err_chan | input | 1 | Failing channel, valid with ev_ce/ev_ue |
| err_syn | input | SYN_W | ECC syndrome, valid with ev_ce/ev_ue |
| reg_we | input | 1 | Register write request |
| reg_re | input | 1 | Register read request |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wstrb | input | 4 | Write byte strobes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| serr | output | 1 | System error pulse |

## Verification
The bench builds the block with its default parameters: a 33-bit physical address, an 8-bit syndrome and an 8-bit register offset. With a 33-bit address, bit 32 is a real bit, so the split between the pointer register and the extended register can be checked with that bit both set and clear. An 8-bit offset reaches every register location, including 0xCA, which is the upper half of the 0xC8 word. The full-width syndrome lets every value written be told apart from the value logged before it.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;
    localparam int STS_W     = 16;
    localparam int BIT_CE    = 0;
    localparam int BIT_UE    = 1;
    localparam int BIT_RFTO  = 8;
    localparam int BIT_LOCK  = 9;
    localparam int BIT_THERM = 11;
    localparam logic [STS_W-1:0] EV_MASK = 16'h0B03;

    localparam int GRAIN_LSB = 7;
    localparam int LOW_AW    = 32;

    localparam int OFS_PTR = 'h58;
    localparam int OFS_SYN = 'h5C;
    localparam int OFS_EXT = 'h70;
    localparam int OFS_STS = 'hC8;

    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic             serr;
    } sts_state_t;

    typedef struct packed {
        logic [STS_W-1:0] cmd;
        logic [31:0]      rdata;
    } reg_state_t;
endpackage

// File: rtl/ecc_err_status.sv
module ecc_err_status
    import ecc_err_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STS_W-1:0] ev_vec,
    input  logic [STS_W-1:0] clr_vec,
    input  logic [STS_W-1:0] cmd,
    output logic [STS_W-1:0] sts_o,
    output logic             serr_o
);
    sts_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < STS_W; i++) begin
            if (EV_MASK[i]) begin
                // a hardware set in the same cycle outranks a clear
                state_d.sts[i] = ev_vec[i] | (state_q.sts[i] & ~clr_vec[i]);
            end else begin
                state_d.sts[i] = 1'b0;
            end
        end
        state_d.serr = |(ev_vec & cmd & EV_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign sts_o  = state_q.sts;
    assign serr_o = state_q.serr;
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_err_log_pkg::*;
#(
    parameter int PA_W  = 33,
    parameter int SYN_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ev_ce,
    input  logic                      ev_ue,
    input  logic [PA_W-GRAIN_LSB-1:0] err_line,
    input  logic                      err_chan,
    input  logic [SYN_W-1:0]          err_syn,
    input  logic                      flag_ce,
    input  logic                      flag_ue,
    output logic [PA_W-GRAIN_LSB-1:0] line_o,
    output logic                      chan_o,
    output logic [SYN_W-1:0]          syn_o
);
    localparam int LINE_W = PA_W - GRAIN_LSB;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              chan;
        logic [SYN_W-1:0]  syn;
    } log_t;

    log_t log_d, log_q;
    logic take_ue, take_ce;

    always_comb begin
        take_ue = ev_ue && !flag_ue;
        take_ce = ev_ce && !ev_ue && !flag_ce && !flag_ue;
        log_d   = log_q;
        if (take_ue || take_ce) begin
            log_d.line = err_line;
            log_d.chan = err_chan;
            log_d.syn  = err_syn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) log_q <= '0;
        else     log_q <= log_d;
    end

    assign line_o = log_q.line;
    assign chan_o = log_q.chan;
    assign syn_o  = log_q.syn;
endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
    import ecc_err_log_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int PA_W   = 33,
    parameter int SYN_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic                      re,
    input  logic [REG_AW-1:0]         addr,
    input  logic [3:0]                wstrb,
    input  logic [31:0]               wdata,
    input  logic [STS_W-1:0]          sts,
    input  logic [PA_W-GRAIN_LSB-1:0] line,
    input  logic                      chan,
    input  logic [SYN_W-1:0]          syn,
    output logic [STS_W-1:0]          cmd_o,
    output logic [STS_W-1:0]          clr_o,
    output logic [31:0]               rdata_o
);
    localparam int LINE_W = PA_W - GRAIN_LSB;
    localparam int EXT_W  = PA_W - LOW_AW;
    localparam int LOW_LW = LOW_AW - GRAIN_LSB;
    localparam int NLANE  = STS_W / 8;

    reg_state_t state_d, state_q;
    logic hit_ptr, hit_syn, hit_ext, hit_sts;
    logic [7:0]  ext_byte;
    logic [31:0] mux;

    always_comb begin
        hit_ptr = (addr == REG_AW'(OFS_PTR));
        hit_syn = (addr == REG_AW'(OFS_SYN));
        hit_ext = (addr == REG_AW'(OFS_EXT));
        hit_sts = (addr == REG_AW'(OFS_STS));

        state_d = state_q;
        clr_o   = '0;
        for (int b = 0; b < NLANE; b++) begin
            if (we && hit_sts && wstrb[b]) begin
                clr_o[8*b +: 8] = wdata[8*b +: 8] & EV_MASK[8*b +: 8];
            end
            if (we && hit_sts && wstrb[NLANE+b]) begin
                state_d.cmd[8*b +: 8] = wdata[16+8*b +: 8] & EV_MASK[8*b +: 8];
            end
        end

        ext_byte = '0;
        ext_byte[EXT_W-1:0] = line[LINE_W-1:LOW_LW];

        mux = '0;
        if (hit_ptr) mux = {line[LOW_LW-1:0], {(GRAIN_LSB-1){1'b0}}, chan};
        if (hit_syn) mux = 32'(syn);
        if (hit_ext) mux = 32'(ext_byte);
        if (hit_sts) mux = {state_q.cmd, sts};

        if (re) state_d.rdata = mux;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign cmd_o   = state_q.cmd;
    assign rdata_o = state_q.rdata;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_err_log_pkg::*;
#(
    parameter int PA_W   = 33,
    parameter int SYN_W  = 8,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_ce,
    input  logic              ev_ue,
    input  logic              ev_rfto,
    input  logic              ev_lock,
    input  logic              ev_therm,
    input  logic [PA_W-1:0]   err_addr,
    input  logic              err_chan,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [3:0]        reg_wstrb,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              serr
);
    localparam int LINE_W = PA_W - GRAIN_LSB;

    logic [STS_W-1:0]  ev_vec, sts_w, clr_w, cmd_w;
    logic [LINE_W-1:0] line_w;
    logic              chan_w;
    logic [SYN_W-1:0]  syn_w;
    logic [6:0]        addr_lo_unused;

    always_comb begin
        ev_vec            = '0;
        ev_vec[BIT_CE]    = ev_ce;
        ev_vec[BIT_UE]    = ev_ue;
        ev_vec[BIT_RFTO]  = ev_rfto;
        ev_vec[BIT_LOCK]  = ev_lock;
        ev_vec[BIT_THERM] = ev_therm;
    end

    assign addr_lo_unused = err_addr[GRAIN_LSB-1:0];

    ecc_err_status u_status (
        .clk     (clk),
        .rst     (rst),
        .ev_vec  (ev_vec),
        .clr_vec (clr_w),
        .cmd     (cmd_w),
        .sts_o   (sts_w),
        .serr_o  (serr)
    );

    ecc_err_capture #(.PA_W(PA_W), .SYN_W(SYN_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .ev_ce    (ev_ce),
        .ev_ue    (ev_ue),
        .err_line (err_addr[PA_W-1:GRAIN_LSB]),
        .err_chan (err_chan),
        .err_syn  (err_syn),
        .flag_ce  (sts_w[BIT_CE]),
        .flag_ue  (sts_w[BIT_UE]),
        .line_o   (line_w),
        .chan_o   (chan_w),
        .syn_o    (syn_w)
    );

    ecc_err_regs #(.REG_AW(REG_AW), .PA_W(PA_W), .SYN_W(SYN_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .re      (reg_re),
        .addr    (reg_addr),
        .wstrb   (reg_wstrb),
        .wdata   (reg_wdata),
        .sts     (sts_w),
        .line    (line_w),
        .chan    (chan_w),
        .syn     (syn_w),
        .cmd_o   (cmd_w),
        .clr_o   (clr_w),
        .rdata_o (reg_rdata)
    );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
    import ecc_err_log_pkg::*;
#(
    parameter int PA_W = 33
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      ev_ce,
    input logic                      ev_ue,
    input logic                      ev_rfto,
    input logic                      ev_lock,
    input logic                      ev_therm,
    input logic [PA_W-GRAIN_LSB-1:0] err_line,
    input logic [STS_W-1:0]          sts_q,
    input logic [STS_W-1:0]          cmd_q,
    input logic [PA_W-GRAIN_LSB-1:0] log_line,
    input logic                      serr
);
    logic any_ev;
    assign any_ev = ev_ce | ev_ue | ev_rfto | ev_lock | ev_therm;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sts_q == '0 && cmd_q == '0 && log_line == '0 && !serr));

    assert_ce_sets_R2: assert property (@(posedge clk) disable iff (rst)
        ev_ce |=> sts_q[BIT_CE]);

    // set outranks any clear issued in the same cycle
    assert_therm_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        ev_therm |=> sts_q[BIT_THERM]);

    assert_ue_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (ev_ue && !sts_q[BIT_UE]) |=> (log_line == $past(err_line)));

    assert_ue_hold_R8: assert property (@(posedge clk) disable iff (rst)
        sts_q[BIT_UE] |=> $stable(log_line));

    assert_serr_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !any_ev |=> !serr);

    assert_serr_ce_R10: assert property (@(posedge clk) disable iff (rst)
        (ev_ce && cmd_q[BIT_CE]) |=> serr);
endmodule

bind ecc_err_log ecc_err_log_chk #(.PA_W(PA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev_ce    (ev_ce),
    .ev_ue    (ev_ue),
    .ev_rfto  (ev_rfto),
    .ev_lock  (ev_lock),
    .ev_therm (ev_therm),
    .err_line (err_addr[PA_W-1:7]),
    .sts_q    (sts_w),
    .cmd_q    (cmd_w),
    .log_line (line_w),
    .serr     (serr)
);

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_ce = 0, ev_ue = 0, ev_rfto = 0, ev_lock = 0, ev_therm = 0;
    logic [32:0] err_addr = '0;
    logic        err_chan = 0;
    logic [7:0]  err_syn = '0;
    logic        reg_we = 0, reg_re = 0;
    logic [7:0]  reg_addr = '0;
    logic [3:0]  reg_wstrb = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        serr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ecc_err_log u0 (
        .clk(clk), .rst(rst),
        .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_rfto(ev_rfto), .ev_lock(ev_lock), .ev_therm(ev_therm),
        .err_addr(err_addr), .err_chan(err_chan), .err_syn(err_syn),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wstrb(reg_wstrb), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .serr(serr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_re = 1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_re = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] s, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wstrb = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_wstrb = '0;
    endtask

    // m = {therm, lock, rfto, ue, ce}
    task automatic pulse(input logic [4:0] m, input logic [32:0] a, input logic c, input logic [7:0] s);
        {ev_therm, ev_lock, ev_rfto, ev_ue, ev_ce} = m;
        err_addr = a; err_chan = c; err_syn = s;
        @(negedge clk);
        {ev_therm, ev_lock, ev_rfto, ev_ue, ev_ce} = '0;
    endtask

    task automatic clear_all();
        wr(8'hC8, 4'b0011, 32'h0000_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 serr after reset", 32'(serr), 0);
        rd(8'hC8, d); check("R1 status/command", d, 0);
        rd(8'h58, d); check("R1 address", d, 0);
        rd(8'h5C, d); check("R1 syndrome", d, 0);
        rd(8'h70, d); check("R1 extended", d, 0);
    endtask

    task automatic t_status_bits();
        logic [31:0] d;
        logic [4:0]  m [5] = '{5'b00001, 5'b00010, 5'b00100, 5'b01000, 5'b10000};
        logic [31:0] e [5] = '{32'h0001, 32'h0002, 32'h0100, 32'h0200, 32'h0800};
        for (int i = 0; i < 5; i++) begin
            clear_all();
            pulse(m[i], 33'h0, 1'b0, 8'h00);
            rd(8'hC8, d); check("R2 single event bit", d, e[i]);
        end
        pulse(5'b11111, 33'h0, 1'b0, 8'h00);
        rd(8'hC8, d); check("R2 all events, reserved zero", d, 32'h0B03);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        clear_all();
        pulse(5'b11111, 33'h0, 1'b0, 8'h00);
        wr(8'hC8, 4'b0011, 32'h0000_0001);
        rd(8'hC8, d); check("R3 clear bit 0 only", d, 32'h0B02);
        wr(8'hC8, 4'b0011, 32'h0000_0000);
        rd(8'hC8, d); check("R3 zero write keeps", d, 32'h0B02);
        wr(8'hC8, 4'b0001, 32'h0000_0B00);
        rd(8'hC8, d); check("R3 strobe off keeps", d, 32'h0B02);
        wr(8'hC8, 4'b0010, 32'h0000_0200);
        rd(8'hC8, d); check("R3 clear bit 9", d, 32'h0902);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        clear_all();
        ev_rfto = 1;
        reg_we = 1; reg_addr = 8'hC8; reg_wstrb = 4'b0011; reg_wdata = 32'h0000_0100;
        @(negedge clk);
        ev_rfto = 0; reg_we = 0; reg_wstrb = '0;
        rd(8'hC8, d); check("R4 set beats clear", d, 32'h0100);
    endtask

    task automatic t_fields();
        logic [31:0] d;
        clear_all();
        pulse(5'b00001, 33'h1_2345_67FF, 1'b1, 8'hA5);
        rd(8'h58, d); check("R5 address pointer", d, 32'h2345_6781);
        rd(8'h70, d); check("R6 extended bit 32", d, 32'h0000_0001);
        rd(8'h5C, d); check("R6 syndrome", d, 32'h0000_00A5);
    endtask

    task automatic t_ue_over_ce();
        logic [31:0] d;
        clear_all();
        pulse(5'b00001, 33'h1_1111_1180, 1'b1, 8'h11);
        pulse(5'b00010, 33'h0_89AB_CD7F, 1'b0, 8'h3C);
        rd(8'h58, d); check("R7 UE replaces address", d, 32'h89AB_CD00);
        rd(8'h70, d); check("R7 UE replaces extended", d, 0);
        rd(8'h5C, d); check("R7 UE replaces syndrome", d, 32'h3C);
    endtask

    task automatic t_no_overwrite();
        logic [31:0] d;
        clear_all();
        pulse(5'b00001, 33'h0_0000_0280, 1'b0, 8'h21);
        pulse(5'b00001, 33'h0_0000_0F80, 1'b1, 8'h22);
        rd(8'h5C, d); check("R8 CE over CE ignored", d, 32'h21);
        pulse(5'b00010, 33'h0_0000_1000, 1'b0, 8'h31);
        pulse(5'b00010, 33'h1_0000_2000, 1'b1, 8'h32);
        rd(8'h58, d); check("R8 UE over UE ignored", d, 32'h0000_1000);
        wr(8'hC8, 4'b0001, 32'h0000_0001);
        pulse(5'b00001, 33'h0_0000_3000, 1'b0, 8'h41);
        rd(8'h5C, d); check("R8 CE ignored while UE flag", d, 32'h31);
        clear_all();
        pulse(5'b00001, 33'h0_0000_4000, 1'b1, 8'h51);
        rd(8'h5C, d); check("R8 CE logged after clear", d, 32'h51);
        clear_all();
        pulse(5'b00011, 33'h1_0000_5080, 1'b0, 8'h61);
        rd(8'h58, d); check("R8 both ECC events same cycle", d, 32'h0000_5080);
        rd(8'h70, d); check("R8 both ECC events extended", d, 1);
    endtask

    task automatic t_cmd();
        logic [31:0] d;
        clear_all();
        wr(8'hC8, 4'b1100, 32'hFFFF_0000);
        rd(8'hC8, d); check("R9 command writable bits", d, 32'h0B03_0000);
        wr(8'hC8, 4'b0100, 32'h0000_0000);
        rd(8'hC8, d); check("R9 command byte strobe", d, 32'h0B00_0000);
    endtask

    task automatic t_serr();
        // command = 0x0B00 here: CE and UE disabled
        ev_ce = 1;
        @(negedge clk); ev_ce = 0;
        check("R10 disabled event no serr", 32'(serr), 0);
        ev_rfto = 1;
        @(negedge clk); ev_rfto = 0;
        check("R10 serr pulse high", 32'(serr), 1);
        @(negedge clk);
        check("R10 serr pulse one cycle", 32'(serr), 0);
        wr(8'hC8, 4'b1100, 32'h0001_0000);
        pulse(5'b00001, 33'h0, 1'b0, 8'h00);
        check("R10 enabled CE serr", 32'(serr), 1);
        wr(8'hC8, 4'b1100, 32'h0000_0000);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        clear_all();
        pulse(5'b00001, 33'h0_CAFE_0080, 1'b0, 8'h77);
        wr(8'h58, 4'b1111, 32'hFFFF_FFFF);
        wr(8'h5C, 4'b1111, 32'hFFFF_FFFF);
        wr(8'h70, 4'b1111, 32'hFFFF_FFFF);
        rd(8'h58, d); check("R11 address read-only", d, 32'hCAFE_0080);
        rd(8'h5C, d); check("R11 syndrome read-only", d, 32'h77);
        rd(8'h70, d); check("R11 extended read-only", d, 0);
    endtask

    task automatic t_read_port();
        logic [31:0] d;
        rd(8'h60, d); check("R12 unmapped reads zero", d, 0);
        rd(8'h59, d); check("R12 unaligned reads zero", d, 0);
        reg_re = 1; reg_addr = 8'h58;
        #2 check("R12 rdata before edge", reg_rdata, 0);
        @(negedge clk); reg_re = 0;
        check("R12 rdata after edge", reg_rdata, 32'hCAFE_0080);
        @(negedge clk);
        check("R12 rdata holds", reg_rdata, 32'hCAFE_0080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_status_bits();
        t_w1c();
        t_set_wins();
        t_fields();
        t_ue_over_ce();
        t_no_overwrite();
        t_cmd();
        t_serr();
        t_readonly();
        t_read_port();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule